// File: doc/BRIEF.md
# Receive Packet Buffer with Per-Packet Status Queue

This block sits between a wire-side writer that delivers received frames one byte at a time and a host that drains them sixteen bits at a time. Payload bytes go into a circular byte memory. A short queue beside it holds one status entry per finished packet. Each entry records the packet's offered byte count and the error code that the writer attached when it closed the packet.

The host always sees the entry of the oldest packet as a status word. It reads the payload of that packet word by word, and a discard strobe drops the packet together with any bytes it has not yet read. Four diagnostic flags are brought out: packet in progress, data overrun, status-queue overrun and sticky underrun. An adapter-failure pulse marks each read that had too few bytes to serve.

A packet starts with its first byte, or with an end strobe that arrives without bytes. An end strobe that arrives together with a byte includes that byte as the last one of the packet.

Top module: `rx_pkt_buffer`

## Requirements
- R1: With no finished packet queued, `host_status` reads 16'h8000. Otherwise bit 15 is 0, bit 14 is the error flag, bits 13:11 are the error type and bits 10:0 are the offered byte count, which saturates at 2047.
- R2: The writer's error flag and 3-bit type are stored unchanged (overrun 000, oversize 001, runt 011, alignment 100, CRC 101). A packet that lost any byte to a full memory is stored with flag 1 and type 000, whatever the writer supplied.
- R3: `host_data` presents the next two unread bytes of the head packet, with the earlier byte in bits 7:0. A `host_rd` strobe consumes them. When a finished packet has a single unread byte left, that byte is presented with bits 15:8 at zero, and the strobe consumes that one byte.
- R4: `host_discard` removes the head status entry and all of that packet's unread bytes, however many words have already been read, so the next packet becomes the head. With no finished packet queued, the strobe changes nothing. Discard takes priority over a read strobe given in the same cycle.
- R5: `fl_stat_overrun` is high while STAT_DEPTH packets are queued. A packet that starts while it is high is dropped entirely: no bytes, no entry and no `rx_complete`. The flag falls once a packet is discarded.
- R6: A byte offered while the memory holds DATA_DEPTH bytes is refused and sets `fl_overrun`. While the flag is high, every offered byte is refused. The flag clears one cycle after at least OVR_RESUME bytes are free.
- R7: A read strobe that cannot be served consumes nothing, sets `fl_underrun` and pulses `adapter_fail` in the next cycle. A read cannot be served when the head is unfinished and has fewer than two unread bytes, or when the head is finished and has no unread bytes. `fl_underrun` stays high until `rx_reset` or `rst_n`.
- R8: `rx_complete` is high for exactly the one cycle after the edge that commits an entry, and `host_status` already shows a queued entry in that cycle.
- R9: `fl_receiving` is high from the cycle after a packet's first byte until the cycle after its end strobe.
- R10: `rx_reset` returns the block to its reset state: empty memory and queue, and all flags low.
- R11: The bytes of an unfinished packet can be read, two at a time, while it is the oldest packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous global reset, active low |
| rx_reset | input | 1 | Synchronous receive reset |
| wr_byte_en | input | 1 | Writer offers a byte |
| wr_byte | input | 8 | Offered byte |
| wr_end | input | 1 | Writer closes the current packet |
| wr_err | input | 1 | Error flag supplied with `wr_end` |
| wr_err_type | input | 3 | Error type supplied with `wr_end` |
| host_rd | input | 1 | Consume the presented data word |
| host_discard | input | 1 | Drop the head packet |
| host_status | output | 16 | Status word of the head packet |
| host_data | output | 16 | Next unread payload word |
| rx_complete | output | 1 | One-cycle pulse when an entry is committed |
| fl_receiving | output | 1 | Packet in progress |
| fl_overrun | output | 1 | Data memory overrun |
| fl_stat_overrun | output | 1 | Status queue full |
| fl_underrun | output | 1 | Sticky read-past-end flag |
| adapter_fail | output | 1 | Pulse after an unserviceable read |

## Verification
The hardest situation to reach is a data overrun in the middle of a packet, followed by recovery. The memory has to be filled by a single packet, bytes have to be refused partway through it, and the host then has to free exactly enough space for the hysteresis to release. After that, a discard must drop a stored count that differs from the offered count. The stimulus gets there with one directed 70-byte packet into the 64-byte memory. It reads two words, checking the flag before and after the threshold, and then sends a fresh packet whose data proves that the discard freed exactly the right number of bytes. Status-queue overrun is reached the same way, with eight one-byte packets and then a ninth that must vanish. Seeded random packet lengths, error codes and partial-read discards cover the rest.

// File: rtl/rx_pkt_pkg.sv
package rx_pkt_pkg;

  localparam int LEN_W = 11;

  typedef struct packed {
    logic             err;
    logic [2:0]       etype;
    logic [LEN_W-1:0] len;
  } rx_stat_t;

  localparam int STAT_W = $bits(rx_stat_t);

  // Offered byte count, saturating at the field maximum.
  function automatic logic [LEN_W-1:0] len_bump(input logic [LEN_W-1:0] cur,
                                                input logic inc);
    if (&cur) return cur;
    return cur + {{(LEN_W-1){1'b0}}, inc};
  endfunction

  // Host-visible status word; bit 15 marks "nothing finished at the head".
  function automatic logic [15:0] status_word(input logic have_head,
                                              input rx_stat_t s);
    if (!have_head) return 16'h8000;
    return {1'b0, s.err, s.etype, s.len};
  endfunction

endpackage

// File: rtl/rx_byte_store.sv
module rx_byte_store #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [7:0]    push_byte,
  input  logic [CW-1:0] pop_amt,
  output logic [CW-1:0] used,
  output logic [7:0]    head_lo,
  output logic [7:0]    head_hi
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW-1:0] rd_ptr_nx1;

  assign rd_ptr_nx1 = rd_ptr + 1'b1;
  assign head_lo    = mem[rd_ptr];
  assign head_hi    = mem[rd_ptr_nx1];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + pop_amt[AW-1:0];
      used   <= used + {{(CW-1){1'b0}}, push} - pop_amt;
    end
  end

  AST_POP_WITHIN_USED: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> pop_amt <= used); // R4
  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> used < CW'(DEPTH)); // R6

endmodule

// File: rtl/rx_stat_queue.sv
module rx_stat_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int NW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [NW-1:0] count
);

  logic [W-1:0]  slot [DEPTH];
  logic [IW-1:0] wi, ri;

  function automatic logic [IW-1:0] wrap_inc(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign head = slot[ri];

  always_ff @(posedge clk) begin
    if (push) slot[wi] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wi <= '0; ri <= '0; count <= '0;
    end else if (clr) begin
      wi <= '0; ri <= '0; count <= '0;
    end else begin
      if (push) wi <= wrap_inc(wi);
      if (pop)  ri <= wrap_inc(ri);
      count <= count + {{(NW-1){1'b0}}, push} - {{(NW-1){1'b0}}, pop};
    end
  end

  AST_NO_QUEUE_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |-> count < NW'(DEPTH)); // R5
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clr) |-> count != '0); // R4

endmodule

// File: rtl/rx_pkt_buffer.sv
module rx_pkt_buffer #(
  parameter int DATA_DEPTH = 64,
  parameter int STAT_DEPTH = 8,
  parameter int OVR_RESUME = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_reset,
  input  logic        wr_byte_en,
  input  logic [7:0]  wr_byte,
  input  logic        wr_end,
  input  logic        wr_err,
  input  logic [2:0]  wr_err_type,
  input  logic        host_rd,
  input  logic        host_discard,
  output logic [15:0] host_status,
  output logic [15:0] host_data,
  output logic        rx_complete,
  output logic        fl_receiving,
  output logic        fl_overrun,
  output logic        fl_stat_overrun,
  output logic        fl_underrun,
  output logic        adapter_fail
);
  import rx_pkt_pkg::*;

  localparam int AW = $clog2(DATA_DEPTH);
  localparam int CW = AW + 1;
  localparam int NW = $clog2(STAT_DEPTH + 1);
  localparam int EW = STAT_W + CW;

  // Packet-in-progress state
  logic             in_pkt, pkt_drop, pkt_ovr;
  logic [LEN_W-1:0] pkt_len;
  logic [CW-1:0]    pkt_stored;
  logic [CW-1:0]    rd_off;
  logic             ovr_flag, unr_flag, fail_q, cmpl_q;

  // Named internal events
  logic          q_full, q_has, drop_now, byte_try, byte_acc, byte_ref;
  logic          ovr_any, commit, do_discard, rd_two, rd_one, rd_bad;
  logic [CW-1:0] used, free_cnt, head_stored, avail, pop_amt;
  logic [NW-1:0] q_count;
  logic [EW-1:0] q_head, q_push;
  logic [7:0]    b_lo, b_hi;
  rx_stat_t      new_stat, head_stat;
  logic [CW-1:0] head_entry_stored;

  assign q_full   = (q_count == NW'(STAT_DEPTH));
  assign q_has    = (q_count != '0);
  assign drop_now = in_pkt ? pkt_drop : q_full;
  assign free_cnt = CW'(DATA_DEPTH) - used;
  assign byte_try = wr_byte_en && !drop_now;
  assign byte_acc = byte_try && !ovr_flag && (used < CW'(DATA_DEPTH));
  assign byte_ref = byte_try && !byte_acc;
  assign ovr_any  = pkt_ovr || byte_ref;
  assign commit   = wr_end && !drop_now;

  assign new_stat.err   = wr_err || ovr_any;
  assign new_stat.etype = ovr_any ? 3'b000 : wr_err_type;
  assign new_stat.len   = len_bump(pkt_len, wr_byte_en);
  assign q_push = {new_stat, pkt_stored + {{(CW-1){1'b0}}, byte_acc}};

  assign {head_stat, head_entry_stored} = q_head;
  assign head_stored = q_has ? head_entry_stored : pkt_stored;
  assign avail       = head_stored - rd_off;

  assign do_discard = host_discard && q_has;
  assign rd_two = host_rd && !host_discard && (avail >= CW'(2));
  assign rd_one = host_rd && !host_discard && q_has && (avail == CW'(1));
  assign rd_bad = host_rd && !host_discard && !rd_two && !rd_one;

  always_comb begin
    pop_amt = '0;
    if (do_discard)  pop_amt = avail;
    else if (rd_two) pop_amt = CW'(2);
    else if (rd_one) pop_amt = CW'(1);
  end

  rx_byte_store #(.DEPTH(DATA_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(rx_reset),
    .push(byte_acc), .push_byte(wr_byte), .pop_amt(pop_amt),
    .used(used), .head_lo(b_lo), .head_hi(b_hi)
  );

  rx_stat_queue #(.DEPTH(STAT_DEPTH), .W(EW)) u_queue (
    .clk(clk), .rst_n(rst_n), .clr(rx_reset),
    .push(commit), .push_data(q_push), .pop(do_discard),
    .head(q_head), .count(q_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt <= 1'b0; pkt_drop <= 1'b0; pkt_ovr <= 1'b0;
      pkt_len <= '0; pkt_stored <= '0; rd_off <= '0;
      ovr_flag <= 1'b0; unr_flag <= 1'b0; fail_q <= 1'b0; cmpl_q <= 1'b0;
    end else if (rx_reset) begin
      in_pkt <= 1'b0; pkt_drop <= 1'b0; pkt_ovr <= 1'b0;
      pkt_len <= '0; pkt_stored <= '0; rd_off <= '0;
      ovr_flag <= 1'b0; unr_flag <= 1'b0; fail_q <= 1'b0; cmpl_q <= 1'b0;
    end else begin
      cmpl_q <= commit;
      fail_q <= rd_bad;
      if (rd_bad) unr_flag <= 1'b1;
      if (byte_try && used == CW'(DATA_DEPTH)) ovr_flag <= 1'b1;
      else if (ovr_flag && free_cnt >= CW'(OVR_RESUME)) ovr_flag <= 1'b0;
      if (wr_end) begin
        in_pkt <= 1'b0; pkt_drop <= 1'b0; pkt_ovr <= 1'b0;
        pkt_len <= '0; pkt_stored <= '0;
      end else begin
        if (wr_byte_en && !in_pkt) begin
          in_pkt   <= 1'b1;
          pkt_drop <= q_full;
        end
        if (byte_ref) pkt_ovr <= 1'b1;
        if (byte_try) pkt_len <= len_bump(pkt_len, 1'b1);
        if (byte_acc) pkt_stored <= pkt_stored + 1'b1;
      end
      if (do_discard) rd_off <= '0;
      else            rd_off <= rd_off + pop_amt;
    end
  end

  assign host_status     = status_word(q_has, head_stat);
  assign host_data       = {rd_one ? 8'h00 : ((q_has && avail == CW'(1)) ? 8'h00 : b_hi), b_lo};
  assign rx_complete     = cmpl_q;
  assign fl_receiving    = in_pkt;
  assign fl_overrun      = ovr_flag;
  assign fl_stat_overrun = q_full;
  assign fl_underrun     = unr_flag;
  assign adapter_fail    = fail_q;

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_underrun && !rx_reset) |=> fl_underrun); // R7
  AST_COMPLETE_SHOWS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    rx_complete |-> !host_status[15]); // R8
  AST_FULL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_stat_overrun && !rx_reset) |=> !rx_complete); // R5
  AST_FAIL_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    adapter_fail |-> fl_underrun); // R7
  AST_READ_UNDER_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_reset && !do_discard) |-> pop_amt <= avail); // R3

endmodule

// File: tb/tb_rx_pkt_buffer.sv
module tb_rx_pkt_buffer;

  localparam int DD = 64;

  logic clk = 1'b0, rst_n = 1'b0, rx_reset = 1'b0;
  logic wr_byte_en = 1'b0, wr_end = 1'b0, wr_err = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic [2:0] wr_err_type = 3'b000;
  logic host_rd = 1'b0, host_discard = 1'b0;
  logic [15:0] host_status, host_data;
  logic rx_complete, fl_receiving, fl_overrun, fl_stat_overrun, fl_underrun, adapter_fail;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rx_pkt_buffer #(.DATA_DEPTH(DD), .STAT_DEPTH(8), .OVR_RESUME(4)) dut (
    .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset),
    .wr_byte_en(wr_byte_en), .wr_byte(wr_byte), .wr_end(wr_end),
    .wr_err(wr_err), .wr_err_type(wr_err_type),
    .host_rd(host_rd), .host_discard(host_discard),
    .host_status(host_status), .host_data(host_data),
    .rx_complete(rx_complete), .fl_receiving(fl_receiving),
    .fl_overrun(fl_overrun), .fl_stat_overrun(fl_stat_overrun),
    .fl_underrun(fl_underrun), .adapter_fail(adapter_fail)
  );

  function automatic logic [7:0] pat(input int pid, input int idx);
    return 8'((pid * 37 + idx * 11 + 5) & 255);
  endfunction

  function automatic logic [15:0] exp_stat(input bit e, input logic [2:0] t, input int len);
    int l;
    l = (len > 2047) ? 2047 : len;
    return {1'b0, e, t, 11'(l)};
  endfunction

  function automatic logic [15:0] exp_word(input int pid, input int len, input int k);
    logic [7:0] hi;
    hi = (2 * k + 1 < len) ? pat(pid, 2 * k + 1) : 8'h00;
    return {hi, pat(pid, 2 * k)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b);
    wr_byte_en = 1'b1; wr_byte = b;
    tick();
    wr_byte_en = 1'b0;
  endtask

  task automatic put_end(input bit e, input logic [2:0] t);
    wr_end = 1'b1; wr_err = e; wr_err_type = t;
    tick();
    wr_end = 1'b0; wr_err = 1'b0; wr_err_type = 3'b000;
  endtask

  task automatic send_pkt(input int pid, input int len, input bit e, input logic [2:0] t);
    for (int i = 0; i < len; i++) put_byte(pat(pid, i));
    put_end(e, t);
  endtask

  task automatic rd_chk(input logic [15:0] exp, input string tag);
    chk(host_data == exp, tag, host_data, exp);
    host_rd = 1'b1;
    tick();
    host_rd = 1'b0;
  endtask

  task automatic discard();
    host_discard = 1'b1;
    tick();
    host_discard = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    tick(); tick();
    rst_n = 1'b1;
    tick();
    // R1 / R10: reset state
    chk(host_status == 16'h8000, "R1 reset status", host_status, 16'h8000);
    chk({fl_receiving, fl_overrun, fl_stat_overrun, fl_underrun, rx_complete} == 5'b0,
        "R10 reset flags", {fl_receiving, fl_overrun, fl_stat_overrun, fl_underrun}, 0);

    // R9 / R8 / R1 / R3: basic odd-length packet
    put_byte(pat(1, 0));
    chk(fl_receiving == 1'b1, "R9 receiving high", fl_receiving, 1);
    for (int i = 1; i < 5; i++) put_byte(pat(1, i));
    put_end(1'b0, 3'b000);
    chk(rx_complete == 1'b1, "R8 complete pulse", rx_complete, 1);
    chk(host_status == exp_stat(0, 3'b000, 5), "R1 status len", host_status, exp_stat(0, 3'b000, 5));
    chk(fl_receiving == 1'b0, "R9 receiving low", fl_receiving, 0);
    tick();
    chk(rx_complete == 1'b0, "R8 pulse one cycle", rx_complete, 0);
    for (int k = 0; k < 3; k++) rd_chk(exp_word(1, 5, k), "R3 word");
    chk(fl_underrun == 1'b0, "R3 no underrun", fl_underrun, 0);
    discard();
    chk(host_status == 16'h8000, "R4 empty after discard", host_status, 16'h8000);

    // R4: discard with nothing queued
    discard();
    chk(host_status == 16'h8000 && !fl_underrun, "R4 empty discard", host_status, 16'h8000);

    // R2: error code passed through
    send_pkt(2, 3, 1'b1, 3'b101);
    chk(host_status == exp_stat(1, 3'b101, 3), "R2 crc code", host_status, exp_stat(1, 3'b101, 3));
    discard();

    // R4: discard after partial read; next packet intact
    send_pkt(3, 6, 1'b0, 3'b000);
    send_pkt(4, 4, 1'b1, 3'b011);
    rd_chk(exp_word(3, 6, 0), "R3 first word");
    discard();
    chk(host_status == exp_stat(1, 3'b011, 4), "R4 next head status", host_status, exp_stat(1, 3'b011, 4));
    rd_chk(exp_word(4, 4, 0), "R4 next head data");
    rd_chk(exp_word(4, 4, 1), "R4 next head data2");
    discard();

    // Random packets
    for (int p = 0; p < 40; p++) begin
      int len, words, nrd;
      bit e;
      logic [2:0] t;
      len = $urandom_range(0, 20);
      e = 1'($urandom_range(0, 1));
      t = 3'($urandom_range(0, 7));
      send_pkt(10 + p, len, e, t);
      chk(host_status == exp_stat(e, t, len), "R2 random status", host_status, exp_stat(e, t, len));
      words = (len + 1) / 2;
      nrd = $urandom_range(0, words);
      for (int k = 0; k < nrd; k++) rd_chk(exp_word(10 + p, len, k), "R3 random word");
      discard();
      chk(host_status == 16'h8000, "R4 random discard", host_status, 16'h8000);
    end

    // R11 / R7: early read of unfinished packet, then underrun
    for (int i = 0; i < 3; i++) put_byte(pat(60, i));
    rd_chk(exp_word(60, 4, 0), "R11 early word");
    chk(fl_underrun == 1'b0, "R11 no underrun", fl_underrun, 0);
    host_rd = 1'b1; tick(); host_rd = 1'b0;
    chk(fl_underrun == 1'b1 && adapter_fail == 1'b1, "R7 underrun set", {fl_underrun, adapter_fail}, 3);
    tick(); tick();
    chk(fl_underrun == 1'b1 && adapter_fail == 1'b0, "R7 sticky", {fl_underrun, adapter_fail}, 2);
    rx_reset = 1'b1; tick(); rx_reset = 1'b0;
    chk(!fl_underrun && !fl_receiving && host_status == 16'h8000, "R10 rx_reset clears",
        {fl_underrun, fl_receiving}, 0);

    // R5: status queue overrun
    for (int p = 0; p < 8; p++) send_pkt(70 + p, 1, 1'b0, 3'b000);
    chk(fl_stat_overrun == 1'b1, "R5 full flag", fl_stat_overrun, 1);
    send_pkt(99, 2, 1'b0, 3'b000);
    chk(rx_complete == 1'b0, "R5 dropped no complete", rx_complete, 0);
    chk(host_status == exp_stat(0, 3'b000, 1), "R5 head unchanged", host_status, exp_stat(0, 3'b000, 1));
    rd_chk(exp_word(70, 1, 0), "R5 head data");
    discard();
    chk(fl_stat_overrun == 1'b0, "R5 flag clears", fl_stat_overrun, 0);
    for (int p = 1; p < 8; p++) begin
      rd_chk(exp_word(70 + p, 1, 0), "R5 remaining data");
      discard();
    end
    chk(host_status == 16'h8000, "R5 dropped packet absent", host_status, 16'h8000);

    // R6: data overrun in mid packet
    for (int i = 0; i < 70; i++) begin
      put_byte(pat(80, i));
      if (i == 64) chk(fl_overrun == 1'b1, "R6 overrun set", fl_overrun, 1);
    end
    put_end(1'b0, 3'b000);
    chk(host_status == exp_stat(1, 3'b000, 70), "R2 overrun code", host_status, exp_stat(1, 3'b000, 70));
    rd_chk(exp_word(80, 70, 0), "R6 stored data");
    chk(fl_overrun == 1'b1, "R6 hold below resume", fl_overrun, 1);
    rd_chk(exp_word(80, 70, 1), "R6 stored data2");
    tick();
    chk(fl_overrun == 1'b0, "R6 overrun clears", fl_overrun, 0);
    discard();
    chk(host_status == 16'h8000, "R4 overrun discard", host_status, 16'h8000);
    send_pkt(90, 4, 1'b0, 3'b000);
    rd_chk(exp_word(90, 4, 0), "R4 discard freed exact count");

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule